// File: doc/BRIEF.md
# Root Port Command Register and Upstream Request Gate

This block holds the 16-bit command register of one PCI Express root port and the gating logic that the register controls. Configuration writes and reads reach the register at offset 04h. A 2-bit byte enable selects which byte of a write takes effect. Four bits can be written. All other bits read as zero, and writes to them are discarded.

Upstream requests enter a small FIFO, each tagged with a 3-bit kind. The block decides whether a request goes upstream or becomes an unsupported request at the moment it leaves the FIFO. It makes that decision from the bus-master enable bit as it stands in that cycle. Clearing the bit therefore also affects requests that are already queued. Message requests are never gated.

A second bit gates error signalling toward the core error logic. This covers fatal and non-fatal errors detected locally and error messages received from the link. Parity reporting is independent of the stored parity-response bit.

Top module: `rp_cmd_gate`

## Requirements
- R1: After reset the register reads 0000h, the FIFO is empty (`up_ready` is 1), and no output valid or error pulse is asserted.
- R2: Bits 2 (bus-master enable), 6 (parity response), 8 (error-report enable) and 10 (legacy interrupt disable) are writable and read back as written. A full write of FFFFh reads back 0544h.
- R3: Bits 15:11 and bits 9, 7, 5, 4 and 3 always read 0 and ignore writes.
- R4: `cfg_be[0]` enables bits 7:0 and `cfg_be[1]` enables bits 15:8. A byte whose enable is 0 keeps its value.
- R5: A write to any offset other than 04h leaves the register unchanged. A read at another offset returns 0.
- R6: With bus-master enable set, dequeued requests appear in arrival order on `dn_fwd_valid`, with kind and data, in the cycle after the dequeue.
- R7: With bus-master enable clear, a dequeued request of any kind other than message (kind 6) raises `dn_ur_valid` instead of `dn_fwd_valid`. The gated kinds are memory read/write (0/1), I/O read/write (2/3) and configuration read/write (4/5).
- R8: A message request (kind 6) is forwarded whatever the value of bus-master enable.
- R9: Each entry is classified with the bus-master enable value in its dequeue cycle. Entries queued while the bit was 1 become unsupported once it is cleared.
- R10: The FIFO holds 4 entries. `up_ready` is 0 when it is full, and a request offered while full is dropped.
- R11: With error-report enable set, a local fatal or non-fatal strobe gives a one-cycle pulse on `core_fatal` or `core_nonfatal` in the next cycle. With the bit clear, no pulse appears.
- R12: Received fatal and non-fatal error messages follow the same gating and timing as R11.
- R13: A parity error strobe gives a pulse on `par_err_report` in the next cycle, whatever the value of bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 12 | Configuration register offset |
| cfg_wdata | input | 16 | Write data |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_rdata | output | 16 | Read data (combinational, 0 on a miss) |
| up_valid | input | 1 | Upstream request offered |
| up_kind | input | 3 | Request kind (0..5 gated kinds, 6 message) |
| up_data | input | 16 | Request payload |
| up_ready | output | 1 | FIFO can accept a request |
| dn_ready | input | 1 | Consumer takes the FIFO head this cycle |
| dn_fwd_valid | output | 1 | Dequeued request forwarded |
| dn_ur_valid | output | 1 | Dequeued request flagged unsupported |
| dn_kind | output | 3 | Kind of the dequeued request |
| dn_data | output | 16 | Payload of the dequeued request |
| loc_fatal | input | 1 | Locally detected fatal error strobe |
| loc_nonfatal | input | 1 | Locally detected non-fatal error strobe |
| rx_err_fatal | input | 1 | Received fatal error message strobe |
| rx_err_nonfatal | input | 1 | Received non-fatal error message strobe |
| par_err_det | input | 1 | Parity/ECC error detected |
| core_fatal | output | 1 | Fatal notification pulse to core error logic |
| core_nonfatal | output | 1 | Non-fatal notification pulse to core error logic |
| par_err_report | output | 1 | Parity error report pulse |

## Verification
The hardest case to reach is a request that was accepted while bus-master enable was 1 and is still queued when the bit is cleared. To reach it, the bench holds `dn_ready` low and fills the FIFO under an enabled register. It then clears the bit with a configuration write and drains the FIFO one entry at a time. The drained entries must come out unsupported, except the message among them. A second pass clears the bit between two dequeues, so that one entry is forwarded and the next is rejected.

// File: rtl/rp_cmd_pkg.sv
package rp_cmd_pkg;

    typedef enum logic [2:0] {
        REQ_MRD   = 3'd0,
        REQ_MWR   = 3'd1,
        REQ_IORD  = 3'd2,
        REQ_IOWR  = 3'd3,
        REQ_CFGRD = 3'd4,
        REQ_CFGWR = 3'd5,
        REQ_MSG   = 3'd6,
        REQ_RSVD  = 3'd7
    } req_kind_e;

    localparam int CMD_W    = 16;
    localparam int BIT_BM   = 2;
    localparam int BIT_PERR = 6;
    localparam int BIT_SERR = 8;
    localparam int BIT_INTX = 10;

    localparam logic [CMD_W-1:0] RW_MASK =
        CMD_W'((1 << BIT_BM) | (1 << BIT_PERR) | (1 << BIT_SERR) | (1 << BIT_INTX));

    typedef struct packed {
        logic intx_dis;
        logic serr_en;
        logic perr_resp;
        logic bm_en;
    } cmd_ctrl_t;

    function automatic logic kind_is_gated(input logic [2:0] k);
        return k != REQ_MSG;
    endfunction

endpackage

// File: rtl/rp_cmd_reg.sv
module rp_cmd_reg
    import rp_cmd_pkg::*;
#(
    parameter int AW     = 12,
    parameter int OFFSET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [CMD_W-1:0] wdata,
    input  logic [1:0]       be,
    output logic [CMD_W-1:0] rdata,
    output logic             bm_en,
    output logic             serr_en
);
    localparam logic [AW-1:0] HIT_ADDR = AW'(OFFSET);

    cmd_ctrl_t ctrl_d, ctrl_q;
    logic      wr_hit, rd_hit;

    assign wr_hit = wr_en && (addr == HIT_ADDR);
    assign rd_hit = rd_en && (addr == HIT_ADDR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            if (be[0]) begin
                ctrl_d.bm_en     = wdata[BIT_BM];
                ctrl_d.perr_resp = wdata[BIT_PERR];
            end
            if (be[1]) begin
                ctrl_d.serr_en  = wdata[BIT_SERR];
                ctrl_d.intx_dis = wdata[BIT_INTX];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata[BIT_BM]   = ctrl_q.bm_en;
            rdata[BIT_PERR] = ctrl_q.perr_resp;
            rdata[BIT_SERR] = ctrl_q.serr_en;
            rdata[BIT_INTX] = ctrl_q.intx_dis;
        end
    end

    assign bm_en   = ctrl_q.bm_en;
    assign serr_en = ctrl_q.serr_en;

    // R3
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~RW_MASK) == '0);

    // R5
    other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != HIT_ADDR) |=> $stable(ctrl_q));

    // R4
    low_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && be == 2'b01) |=> ($stable(ctrl_q.serr_en) && $stable(ctrl_q.intx_dis)));

    // R2
    bm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && be[0]) |=> (ctrl_q.bm_en == $past(wdata[BIT_BM])));

endmodule

// File: rtl/rp_req_queue.sv
module rp_req_queue
    import rp_cmd_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bm_en,
    input  logic          in_valid,
    input  logic [2:0]    in_kind,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          out_ready,
    output logic          fwd_valid,
    output logic          ur_valid,
    output logic [2:0]    out_kind,
    output logic [DW-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = 3 + DW;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic [PW-1:0]            rptr;
        logic [CW-1:0]            count;
        logic                     fwd_v;
        logic                     ur_v;
        logic [EW-1:0]            out;
    } q_state_t;

    q_state_t      st_d, st_q;
    logic          push, pop, gated;
    logic [EW-1:0] head;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign in_ready = (st_q.count != CW'(DEPTH));
    assign push     = in_valid && in_ready;
    assign pop      = (st_q.count != '0) && out_ready;
    assign head     = st_q.mem[st_q.rptr];
    assign gated    = kind_is_gated(head[EW-1 -: 3]) && !bm_en;

    always_comb begin
        st_d       = st_q;
        st_d.fwd_v = 1'b0;
        st_d.ur_v  = 1'b0;
        if (push) begin
            st_d.mem[st_q.wptr] = {in_kind, in_data};
            st_d.wptr           = bump(st_q.wptr);
        end
        if (pop) begin
            st_d.out   = head;
            st_d.fwd_v = !gated;
            st_d.ur_v  = gated;
            st_d.rptr  = bump(st_q.rptr);
        end
        st_d.count = st_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fwd_valid = st_q.fwd_v;
    assign ur_valid  = st_q.ur_v;
    assign out_kind  = st_q.out[EW-1 -: 3];
    assign out_data  = st_q.out[DW-1:0];

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CW'(DEPTH) && !out_ready) |=> (st_q.count == CW'(DEPTH)));

    // R7
    ur_needs_bm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ur_valid |-> !$past(bm_en));

    // R8
    msg_never_ur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ur_valid |-> (out_kind != REQ_MSG));

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && ur_valid));

endmodule

// File: rtl/rp_err_gate.sv
module rp_err_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic serr_en,
    input  logic loc_fatal,
    input  logic loc_nonfatal,
    input  logic rx_fatal,
    input  logic rx_nonfatal,
    input  logic par_det,
    output logic core_fatal,
    output logic core_nonfatal,
    output logic par_report
);
    typedef struct packed {
        logic fatal;
        logic nonfatal;
        logic par;
    } err_state_t;

    err_state_t es_d, es_q;

    always_comb begin
        es_d.fatal    = serr_en && (loc_fatal || rx_fatal);
        es_d.nonfatal = serr_en && (loc_nonfatal || rx_nonfatal);
        es_d.par      = par_det;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

    assign core_fatal    = es_q.fatal;
    assign core_nonfatal = es_q.nonfatal;
    assign par_report    = es_q.par;

    // R11
    fatal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_fatal |-> $past(serr_en));

    // R12
    nonfatal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_nonfatal |-> $past(serr_en));

endmodule

// File: rtl/rp_cmd_gate.sv
module rp_cmd_gate
    import rp_cmd_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_rd,
    input  logic [AW-1:0] cfg_addr,
    input  logic [15:0]   cfg_wdata,
    input  logic [1:0]    cfg_be,
    output logic [15:0]   cfg_rdata,
    input  logic          up_valid,
    input  logic [2:0]    up_kind,
    input  logic [DW-1:0] up_data,
    output logic          up_ready,
    input  logic          dn_ready,
    output logic          dn_fwd_valid,
    output logic          dn_ur_valid,
    output logic [2:0]    dn_kind,
    output logic [DW-1:0] dn_data,
    input  logic          loc_fatal,
    input  logic          loc_nonfatal,
    input  logic          rx_err_fatal,
    input  logic          rx_err_nonfatal,
    input  logic          par_err_det,
    output logic          core_fatal,
    output logic          core_nonfatal,
    output logic          par_err_report
);
    logic bm_en, serr_en;

    rp_cmd_reg #(.AW(AW), .OFFSET(4)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .rd_en   (cfg_rd),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .be      (cfg_be),
        .rdata   (cfg_rdata),
        .bm_en   (bm_en),
        .serr_en (serr_en)
    );

    rp_req_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .bm_en     (bm_en),
        .in_valid  (up_valid),
        .in_kind   (up_kind),
        .in_data   (up_data),
        .in_ready  (up_ready),
        .out_ready (dn_ready),
        .fwd_valid (dn_fwd_valid),
        .ur_valid  (dn_ur_valid),
        .out_kind  (dn_kind),
        .out_data  (dn_data)
    );

    rp_err_gate u_err (
        .clk           (clk),
        .rst_n         (rst_n),
        .serr_en       (serr_en),
        .loc_fatal     (loc_fatal),
        .loc_nonfatal  (loc_nonfatal),
        .rx_fatal      (rx_err_fatal),
        .rx_nonfatal   (rx_err_nonfatal),
        .par_det       (par_err_det),
        .core_fatal    (core_fatal),
        .core_nonfatal (core_nonfatal),
        .par_report    (par_err_report)
    );

endmodule

// File: tb/rp_cmd_gate_test.sv
module rp_cmd_gate_test;
    import rp_cmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_rdata;
    logic        up_valid = 1'b0;
    logic [2:0]  up_kind = '0;
    logic [15:0] up_data = '0;
    logic        up_ready;
    logic        dn_ready = 1'b0;
    logic        dn_fwd_valid, dn_ur_valid;
    logic [2:0]  dn_kind;
    logic [15:0] dn_data;
    logic        loc_fatal = 1'b0, loc_nonfatal = 1'b0;
    logic        rx_err_fatal = 1'b0, rx_err_nonfatal = 1'b0, par_err_det = 1'b0;
    logic        core_fatal, core_nonfatal, par_err_report;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rp_cmd_gate uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        #1 v = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic push(input logic [2:0] k, input logic [15:0] d);
        @(negedge clk);
        up_valid = 1'b1; up_kind = k; up_data = d;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic pop_one(output logic fv, output logic uv, output logic [2:0] k, output logic [15:0] d);
        @(negedge clk);
        dn_ready = 1'b1;
        @(negedge clk);
        dn_ready = 1'b0;
        fv = dn_fwd_valid; uv = dn_ur_valid; k = dn_kind; d = dn_data;
    endtask

    // bits: {par, rx_nonfatal, rx_fatal, loc_nonfatal, loc_fatal}; result {par, nonfatal, fatal}
    task automatic pulse(input logic [4:0] v, output logic [2:0] r);
        @(negedge clk);
        {par_err_det, rx_err_nonfatal, rx_err_fatal, loc_nonfatal, loc_fatal} = v;
        @(negedge clk);
        {par_err_det, rx_err_nonfatal, rx_err_fatal, loc_nonfatal, loc_fatal} = '0;
        r = {par_err_report, core_nonfatal, core_fatal};
    endtask

    task automatic t_reset();
        logic [15:0] v;
        cfg_read(12'h004, v);
        chk("R1 reset register value", v, 0);
        chk("R1 reset fifo empty", up_ready, 1);
        chk("R1 reset outputs idle",
            {dn_fwd_valid, dn_ur_valid, core_fatal, core_nonfatal, par_err_report}, 0);
    endtask

    task automatic t_rw();
        logic [15:0] v;
        cfg_write(12'h004, 16'hFFFF, 2'b11);
        cfg_read(12'h004, v);
        chk("R2 R3 full write readback", v, 16'h0544);
        cfg_write(12'h004, 16'hFABB, 2'b11);
        cfg_read(12'h004, v);
        chk("R3 fixed bits ignore writes", v, 16'h0000);
        cfg_write(12'h004, 16'h0104, 2'b11);
        cfg_read(12'h004, v);
        chk("R2 partial pattern readback", v, 16'h0104);
        cfg_write(12'h004, 16'h0000, 2'b11);
    endtask

    task automatic t_be();
        logic [15:0] v;
        cfg_write(12'h004, 16'hFFFF, 2'b01);
        cfg_read(12'h004, v);
        chk("R4 low lane only", v, 16'h0044);
        cfg_write(12'h004, 16'hFFFF, 2'b10);
        cfg_read(12'h004, v);
        chk("R4 high lane added", v, 16'h0544);
        cfg_write(12'h004, 16'h0000, 2'b10);
        cfg_read(12'h004, v);
        chk("R4 high lane cleared, low kept", v, 16'h0044);
        cfg_write(12'h004, 16'h0000, 2'b00);
        cfg_read(12'h004, v);
        chk("R4 no lanes enabled", v, 16'h0044);
        cfg_write(12'h004, 16'h0000, 2'b11);
    endtask

    task automatic t_offset();
        logic [15:0] v;
        cfg_write(12'h008, 16'hFFFF, 2'b11);
        cfg_read(12'h004, v);
        chk("R5 write elsewhere ignored", v, 0);
        cfg_write(12'h004, 16'h0004, 2'b01);
        cfg_read(12'h006, v);
        chk("R5 read elsewhere is zero", v, 0);
        cfg_write(12'h004, 16'h0000, 2'b11);
    endtask

    task automatic t_forward();
        logic fv, uv; logic [2:0] k; logic [15:0] d;
        cfg_write(12'h004, 16'h0004, 2'b01);
        push(REQ_MRD, 16'h0011);
        push(REQ_IOWR, 16'h0022);
        push(REQ_CFGRD, 16'h0033);
        pop_one(fv, uv, k, d);
        chk("R6 first forwarded", {fv, uv, k, d}, {1'b1, 1'b0, REQ_MRD, 16'h0011});
        pop_one(fv, uv, k, d);
        chk("R6 second forwarded", {fv, uv, k, d}, {1'b1, 1'b0, REQ_IOWR, 16'h0022});
        pop_one(fv, uv, k, d);
        chk("R6 third forwarded", {fv, uv, k, d}, {1'b1, 1'b0, REQ_CFGRD, 16'h0033});
    endtask

    task automatic t_unsupported();
        logic fv, uv; logic [2:0] k; logic [15:0] d;
        cfg_write(12'h004, 16'h0000, 2'b01);
        push(REQ_MWR, 16'h0044);
        pop_one(fv, uv, k, d);
        chk("R7 memory write unsupported", {fv, uv, k, d}, {1'b0, 1'b1, REQ_MWR, 16'h0044});
        push(REQ_MSG, 16'h0055);
        pop_one(fv, uv, k, d);
        chk("R8 message bypasses gate", {fv, uv, k, d}, {1'b1, 1'b0, REQ_MSG, 16'h0055});
        push(REQ_CFGWR, 16'h0066);
        pop_one(fv, uv, k, d);
        chk("R7 config write unsupported", {fv, uv}, {1'b0, 1'b1});
    endtask

    task automatic t_queued();
        logic fv, uv; logic [2:0] k; logic [15:0] d;
        cfg_write(12'h004, 16'h0004, 2'b01);
        push(REQ_MRD, 16'h0101);
        push(REQ_MSG, 16'h0102);
        push(REQ_IORD, 16'h0103);
        push(REQ_MWR, 16'h0104);
        chk("R10 full deasserts ready", up_ready, 0);
        push(REQ_MWR, 16'h0999);
        cfg_write(12'h004, 16'h0000, 2'b01);
        pop_one(fv, uv, k, d);
        chk("R9 queued read now unsupported", {fv, uv, d}, {1'b0, 1'b1, 16'h0101});
        pop_one(fv, uv, k, d);
        chk("R9 queued message forwarded", {fv, uv, d}, {1'b1, 1'b0, 16'h0102});
        pop_one(fv, uv, k, d);
        chk("R9 queued io read unsupported", {fv, uv, d}, {1'b0, 1'b1, 16'h0103});
        pop_one(fv, uv, k, d);
        chk("R9 queued write unsupported", {fv, uv, d}, {1'b0, 1'b1, 16'h0104});
        pop_one(fv, uv, k, d);
        chk("R10 push while full dropped", {fv, uv}, 2'b00);
        chk("R10 ready after drain", up_ready, 1);
        cfg_write(12'h004, 16'h0004, 2'b01);
        push(REQ_MWR, 16'h00A1);
        push(REQ_IORD, 16'h00A2);
        pop_one(fv, uv, k, d);
        chk("R9 before clear forwarded", {fv, uv, d}, {1'b1, 1'b0, 16'h00A1});
        cfg_write(12'h004, 16'h0000, 2'b01);
        pop_one(fv, uv, k, d);
        chk("R9 after clear unsupported", {fv, uv, d}, {1'b0, 1'b1, 16'h00A2});
    endtask

    task automatic t_errors();
        logic [2:0] r;
        cfg_write(12'h004, 16'h0000, 2'b11);
        pulse(5'b00001, r);
        chk("R11 local fatal blocked", r, 3'b000);
        pulse(5'b01000, r);
        chk("R12 rx nonfatal blocked", r, 3'b000);
        cfg_write(12'h004, 16'h0100, 2'b10);
        pulse(5'b00001, r);
        chk("R11 local fatal notified", r, 3'b001);
        @(negedge clk);
        chk("R11 single cycle pulse", {core_nonfatal, core_fatal}, 2'b00);
        pulse(5'b00010, r);
        chk("R11 local nonfatal notified", r, 3'b010);
        pulse(5'b00100, r);
        chk("R12 rx fatal notified", r, 3'b001);
        pulse(5'b01000, r);
        chk("R12 rx nonfatal notified", r, 3'b010);
        cfg_write(12'h004, 16'h0000, 2'b11);
    endtask

    task automatic t_parity();
        logic [2:0] r;
        pulse(5'b10000, r);
        chk("R13 parity reported with bit6 clear", r, 3'b100);
        cfg_write(12'h004, 16'h0040, 2'b01);
        pulse(5'b10000, r);
        chk("R13 parity reported with bit6 set", r, 3'b100);
        pulse(5'b00000, r);
        chk("R13 no parity without strobe", r, 3'b000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw();
        t_be();
        t_offset();
        t_forward();
        t_unsupported();
        t_queued();
        t_errors();
        t_parity();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule